// File: doc/BRIEF.md
# Slot interrupt status aggregator

This block gathers network interrupt requests from up to five module bays and folds them into two 16-bit status words. Each word is active-low: a 0 bit marks a pending request and a 1 bit marks an idle source. Requests reach the block as one-cycle event pulses. A set event marks a slot/port as pending, and a clear event marks it idle again. Each event carries a slot number and a port number. A fixed routing table places each slot in one of the two words at its own bit offset.

The CPU reads either word through a small combinational read port. The status words cannot be written by software; only set and clear events change them. A single registered, level-sensitive interrupt line tells the CPU when anything is pending. It stays high for as long as either word holds a 0 bit.

Top module: `slot_irq_aggr`

## Requirements
- R1: During and right after synchronous reset, both status words read 0xFFFF and `irq_out` is low.
- R2: A set event drives the addressed status bit to 0, and a clear event drives it back to 1. All other bits keep their values.
- R3: Slot 0 routes to word 0 and uses bit number = port, for any port 0 to 15.
- R4: Slots 1, 2, 3 and 4 route to word 1 at bit number 0, 4, 8 and 12 plus the port, for ports 0 to 3.
- R5: `irq_out` is 1 exactly when, on the previous clock edge, either word differed from 0xFFFF. It therefore lags a status change by one clock.
- R6: If a set and a clear address the same bit in one cycle, the bit becomes 0 (the set wins). If they address different bits, both take effect.
- R7: An event with slot number 5, 6 or 7 changes nothing.
- R8: An event for slots 1 to 4 with a port above 3 changes nothing.
- R9: The read data is combinational. Address 0x20 returns word 0, address 0x22 returns word 1, and every other address returns 0xFFFF.
- R10: In a cycle with no valid event, both status words hold their values, whatever the read port does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Set event strobe (marks pending) |
| set_slot | input | 3 | Slot of the set event |
| set_port | input | 4 | Port of the set event |
| clr_valid | input | 1 | Clear event strobe (marks idle) |
| clr_slot | input | 3 | Slot of the clear event |
| clr_port | input | 4 | Port of the clear event |
| rd_addr | input | 8 | Read address (0x20 or 0x22) |
| rd_data | output | 16 | Selected status word, active-low |
| irq_out | output | 1 | Registered level interrupt to the CPU |

## Verification
A set event and a clear event can arrive in the same cycle, both aimed at one bit or at two different bits. The bench provokes both cases by driving the two strobes on the same falling edge. When they aim at the same bit, the word read back afterwards must show that bit at 0. When they aim at two different bits, each bit must follow its own event. The `irq_out` value sampled in the same cycle is judged against the status held before that edge.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int SLOT_W    = 3;
    localparam int PORT_W    = 4;
    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 2;
    localparam int ADDR_W    = 8;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int SPAN_W    = BIT_W + 1;
    localparam int NARROW_SPAN = 4;

    localparam logic [ADDR_W-1:0] RD_WORD0 = 8'h20;
    localparam logic [ADDR_W-1:0] RD_WORD1 = 8'h22;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] status_vec_t;

    typedef struct packed {
        logic              word;
        logic [BIT_W-1:0]  base;
        logic [SPAN_W-1:0] span;
    } slot_route_t;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        logic [PORT_W-1:0] port;
    } irq_event_t;

    function automatic slot_route_t route_of(input logic [SLOT_W-1:0] s);
        slot_route_t r;
        if (s == '0) begin
            r.word = 1'b0;
            r.base = '0;
            r.span = SPAN_W'(WORD_W);
        end else begin
            r.word = 1'b1;
            r.base = {s[1:0] - 2'd1, 2'b00};
            r.span = SPAN_W'(NARROW_SPAN);
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_irq_decode.sv
module slot_irq_decode
    import slot_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  irq_event_t  ev,
    output status_vec_t hit
);
    slot_route_t      rt;
    logic [SPAN_W-1:0] pos;
    logic              in_range;

    always_comb begin
        rt       = route_of(ev.slot);
        pos      = SPAN_W'(rt.base) + SPAN_W'(ev.port);
        in_range = (int'(ev.slot) < NUM_SLOTS) && ({1'b0, ev.port} < rt.span);
        hit      = '0;
        if (ev.valid && in_range)
            hit[rt.word][pos[BIT_W-1:0]] = 1'b1;
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)) else $error("decode hit more than one bit"); // R3

    AST_BAD_SLOT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && int'(ev.slot) >= NUM_SLOTS) |-> (hit == '0)) else $error("slot out of range decoded"); // R7

    AST_WIDE_PORT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.slot != '0 && int'(ev.port) >= NARROW_SPAN) |-> (hit == '0)) else $error("port beyond field decoded"); // R8

endmodule

// File: rtl/slot_irq_status.sv
module slot_irq_status
    import slot_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  status_vec_t set_hit,
    input  status_vec_t clr_hit,
    output status_vec_t words
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[w] <= '1;
            else
                words[w] <= (words[w] | clr_hit[w]) & ~set_hit[w];
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (words == '1)) else $error("words not idle after reset"); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_hit != '0) |=> ((words & $past(set_hit)) == '0)) else $error("set bit not pending"); // R6

    AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (rst)
        ((clr_hit & ~set_hit) != '0) |=> ((words & $past(clr_hit & ~set_hit)) == $past(clr_hit & ~set_hit))) else $error("clear did not restore"); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (set_hit == '0 && clr_hit == '0) |=> $stable(words)) else $error("words moved without event"); // R10

endmodule

// File: rtl/slot_irq_aggr.sv
module slot_irq_aggr
    import slot_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_valid,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_out
);
    localparam int NUM_KINDS = 2;
    localparam int KIND_SET  = 0;
    localparam int KIND_CLR  = 1;

    irq_event_t  evs  [NUM_KINDS];
    status_vec_t hits [NUM_KINDS];
    status_vec_t words;
    logic        pending;

    assign evs[KIND_SET] = '{valid: set_valid, slot: set_slot, port: set_port};
    assign evs[KIND_CLR] = '{valid: clr_valid, slot: clr_slot, port: clr_port};

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_dec
        slot_irq_decode u_dec (
            .clk (clk),
            .rst (rst),
            .ev  (evs[k]),
            .hit (hits[k])
        );
    end

    slot_irq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_hit (hits[KIND_SET]),
        .clr_hit (hits[KIND_CLR]),
        .words   (words)
    );

    assign pending = (words != '1);

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= 1'b0;
        else
            irq_out <= pending;
    end

    always_comb begin
        unique case (rd_addr)
            RD_WORD0: rd_data = words[0];
            RD_WORD1: rd_data = words[1];
            default:  rd_data = '1;
        endcase
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(words != '1))) else $error("irq does not follow status"); // R5

    AST_IRQ_RESET_LOW: assert property (@(posedge clk)
        rst |=> !irq_out) else $error("irq high after reset"); // R1

endmodule

// File: tb/tb_slot_irq_aggr.sv
`timescale 1ns/1ps
module tb_slot_irq_aggr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_valid = 1'b0;
    logic [2:0]  set_slot = '0;
    logic [3:0]  set_port = '0;
    logic        clr_valid = 1'b0;
    logic [2:0]  clr_slot = '0;
    logic [3:0]  clr_port = '0;
    logic [7:0]  rd_addr = 8'h20;
    logic [15:0] rd_data;
    logic        irq_out;

    always #4 clk = ~clk;

    slot_irq_aggr dut (
        .clk(clk), .rst(rst),
        .set_valid(set_valid), .set_slot(set_slot), .set_port(set_port),
        .clr_valid(clr_valid), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    typedef struct {
        logic [15:0] w0;
        logic [15:0] w1;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] m0 = 16'hFFFF;
    logic [15:0] m1 = 16'hFFFF;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Returns -1 when ignored, 0..15 for word 0, 16..31 for word 1
    function automatic int target(input logic [2:0] s, input logic [3:0] p);
        if (s == 3'd0) return int'(p);
        if (s <= 3'd4 && p <= 4'd3) return 16 + (int'(s) - 1) * 4 + int'(p);
        return -1;
    endfunction

    task automatic step(input logic sv, input logic [2:0] ss, input logic [3:0] sp,
                        input logic cv, input logic [2:0] cs, input logic [3:0] cp,
                        input string tag);
        exp_t it;
        int   t;
        @(negedge clk);
        set_valid = sv; set_slot = ss; set_port = sp;
        clr_valid = cv; clr_slot = cs; clr_port = cp;
        it.irq = (m0 != 16'hFFFF) || (m1 != 16'hFFFF);
        if (cv) begin
            t = target(cs, cp);
            if (t >= 16) m1[t-16] = 1'b1; else if (t >= 0) m0[t] = 1'b1;
        end
        if (sv) begin
            t = target(ss, sp);
            if (t >= 16) m1[t-16] = 1'b0; else if (t >= 0) m0[t] = 1'b0;
        end
        it.w0 = m0; it.w1 = m1; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 4'd0, 1'b0, 3'd0, 4'd0, tag);
    endtask

    // Monitor: pops expected items and compares them a little after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                rd_addr = 8'h20; #1;
                check(rd_data, it.w0, {it.tag, " word0"});
                rd_addr = 8'h22; #1;
                check(rd_data, it.w1, {it.tag, " word1"});
                check({15'd0, irq_out}, {15'd0, it.irq}, {it.tag, " irq R5"});
                rd_addr = 8'h24; #0.5;
                check(rd_data, 16'hFFFF, "R9 unmapped address");
                rd_addr = 8'h20;
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.push_back('{w0: 16'hFFFF, w1: 16'hFFFF, irq: 1'b0, tag: "R1 reset"});
        @(posedge clk);
        idle("R1 idle after reset");
        // R2/R3: slot 0 port 0, then back
        step(1, 3'd0, 4'd0, 0, 3'd0, 4'd0, "R2 R3 set slot0 port0");
        idle("R10 hold");
        step(0, 3'd0, 4'd0, 1, 3'd0, 4'd0, "R2 clear slot0 port0");
        idle("R5 irq falls");
        // R3: top port of slot 0
        step(1, 3'd0, 4'd15, 0, 3'd0, 4'd0, "R3 slot0 port15");
        // R4: slots 1..4
        step(1, 3'd1, 4'd0, 0, 3'd0, 4'd0, "R4 slot1 port0");
        step(1, 3'd2, 4'd1, 0, 3'd0, 4'd0, "R4 slot2 port1");
        step(1, 3'd3, 4'd2, 0, 3'd0, 4'd0, "R4 slot3 port2");
        step(1, 3'd4, 4'd3, 0, 3'd0, 4'd0, "R4 slot4 port3");
        // R7: bad slots
        step(1, 3'd5, 4'd0, 0, 3'd0, 4'd0, "R7 set slot5");
        step(0, 3'd0, 4'd0, 1, 3'd7, 4'd1, "R7 clear slot7");
        // R8: port beyond narrow field
        step(1, 3'd2, 4'd4, 0, 3'd0, 4'd0, "R8 set slot2 port4");
        step(0, 3'd0, 4'd0, 1, 3'd4, 4'd7, "R8 clear slot4 port7");
        // R6: same bit, set wins
        step(1, 3'd3, 4'd0, 1, 3'd3, 4'd0, "R6 same bit set wins");
        // R6: different bits both apply
        step(1, 3'd1, 4'd1, 1, 3'd1, 4'd0, "R6 different bits");
        idle("R10 hold");
        // return everything to idle
        step(0, 3'd0, 4'd0, 1, 3'd0, 4'd15, "R2 clear slot0 port15");
        step(0, 3'd0, 4'd0, 1, 3'd1, 4'd1, "R2 clear slot1 port1");
        step(0, 3'd0, 4'd0, 1, 3'd2, 4'd1, "R2 clear slot2 port1");
        step(0, 3'd0, 4'd0, 1, 3'd3, 4'd2, "R2 clear slot3 port2");
        step(0, 3'd0, 4'd0, 1, 3'd4, 4'd3, "R2 clear slot4 port3");
        step(0, 3'd0, 4'd0, 1, 3'd3, 4'd0, "R2 clear slot3 port0");
        idle("R5 irq low again");
        idle("R10 hold");
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule